// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a memory-mapped watchdog timer on a simple single-cycle register bus. A down-counter is loaded from a programmable load register and restarted whenever software writes the reload register. While the counter is running it decrements once per clock. When it expires it raises a pending interrupt and reloads itself. If the interrupt is still pending at the next expiry and the reset output is enabled, the block emits a one-cycle system reset request.

Every register except the lock register is write-protected. A 32-bit key written to the lock register opens the block, and any other value written there closes it again. Interrupt clears are rate-limited: after a clear is accepted, a busy flag shows for a fixed number of cycles. Software must poll that flag until it reads zero before it writes another clear.

The bus is a plain register port, not a stream. `bus_sel` with `bus_wr` high commits a write at the rising clock edge. `bus_sel` with `bus_wr` low returns read data combinationally in the same cycle. Reads are always accepted and have no back-pressure.

Top module: `keylock_wdt`

## Requirements
- R1: After reset the block is locked (lock register 0x13C reads 1), the load register 0x108 reads 0xFFFFFFFF, the counter value 0x118 reads 0xFFFFFFFF, the mask register 0x124 reads 1, and the enable (0x110), control (0x104) and status (0x000) registers read 0. Both outputs are low.
- R2: Writing 0x378F0765 to 0x13C unlocks the block, so bit 0 reads 0. Writing any other value there locks it, so bit 0 reads 1.
- R3: While the block is locked, bus writes to every register other than 0x13C leave all state unchanged.
- R4: Any accepted write to 0x114 copies the load register into the counter, whatever the write data. The counter can be read at 0x118.
- R5: With enable bit 0 set, the counter drops by one each clock. In the cycle after it reads 0, it sets status bit 0 and reloads from the load register. With enable bit 0 clear, the counter holds its value.
- R6: `irq_o` is high exactly when status bit 0 is set and mask bit 0 (0x124) is 0.
- R7: An expiry that finds status bit 0 already set, while control bit 0 is 1, drives `sys_rst_req_o` high for exactly one cycle.
- R8: A write to 0x120 with bit 0 set clears status bit 0 if the clear-busy flag is 0. After such a clear, bit 1 of 0x120 reads 1 for two cycles. A write with bit 0 at 0, or a write made while busy, clears nothing.
- R9: Reads of unmapped offsets and of the reload register 0x114 return 0. A read of 0x120 returns only the busy flag in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| irq_o | output | 1 | Unmasked pending-expiry interrupt |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench first writes protected registers while the block is locked, then repeats the same writes after unlocking. This separates a lock that gates writes from one that only reports its state. The counter is run with a small load value and sampled in the cycle before and the cycle after it reaches zero, which catches an off-by-one in the expiry and the reload. A second expiry with the interrupt still pending tests the reset escalation and the width of its pulse. The interrupt is then cleared with bit 0 at 0 and at 1, and the busy window is timed, which tells the data-gated clear and the hold counter apart from a plain write strobe.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned BUS_W = 32;
  localparam logic [11:0] OFF_STATUS = 12'h000;
  localparam logic [11:0] OFF_CTRL   = 12'h104;
  localparam logic [11:0] OFF_LOAD   = 12'h108;
  localparam logic [11:0] OFF_ENABLE = 12'h110;
  localparam logic [11:0] OFF_RELOAD = 12'h114;
  localparam logic [11:0] OFF_VALUE  = 12'h118;
  localparam logic [11:0] OFF_CLEAR  = 12'h120;
  localparam logic [11:0] OFF_MASK   = 12'h124;
  localparam logic [11:0] OFF_LOCK   = 12'h13C;
  localparam logic [31:0] DEFAULT_KEY = 32'h378F_0765;
endpackage

// File: rtl/wdt_lock.sv
module wdt_lock #(
  parameter logic [31:0] KEY = 32'h378F_0765
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lock_wr,
  input  logic [31:0] wdata,
  output logic        locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked <= 1'b1;
    else if (lock_wr) locked <= (wdata != KEY);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload_stb,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '1;
    else if (reload_stb || expire) cnt <= load_val;
    else if (run)                 cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wdt_irq.sv
module wdt_irq #(
  parameter int unsigned CLR_HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic rst_en,
  input  logic clr_req,
  output logic pending,
  output logic busy,
  output logic rst_req
);
  localparam int unsigned HW = $clog2(CLR_HOLD + 1);
  logic [HW-1:0] hold;
  logic          clr_ok;

  assign busy   = (hold != '0);
  assign clr_ok = clr_req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      hold    <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire && pending && rst_en;
      if (expire)      pending <= 1'b1;
      else if (clr_ok) pending <= 1'b0;
      if (clr_ok)      hold <= HW'(CLR_HOLD);
      else if (busy)   hold <= hold - 1'b1;
    end
  end
endmodule

// File: rtl/keylock_wdt.sv
module keylock_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned   ADDR_W   = 12,
  parameter int unsigned   CNT_W    = 32,
  parameter int unsigned   CLR_HOLD = 2,
  parameter logic [31:0]   KEY      = DEFAULT_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  logic             wr_any, rd_any, locked, wr_open;
  logic             ctrl_rst_en, en_run, mask_q;
  logic [CNT_W-1:0] load_q, cnt;
  logic             expire, pending, busy, rst_req;
  logic             reload_stb, clr_req;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] off);
    return a == ADDR_W'(off);
  endfunction

  assign wr_any     = bus_sel && bus_wr;
  assign rd_any     = bus_sel && !bus_wr;
  assign wr_open    = wr_any && !locked;
  assign reload_stb = wr_open && hit(bus_addr, OFF_RELOAD);
  assign clr_req    = wr_open && hit(bus_addr, OFF_CLEAR) && bus_wdata[0];

  wdt_lock #(.KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .lock_wr(wr_any && hit(bus_addr, OFF_LOCK)),
    .wdata(bus_wdata), .locked(locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_rst_en <= 1'b0;
      en_run      <= 1'b0;
      mask_q      <= 1'b1;
      load_q      <= '1;
    end else if (wr_open) begin
      if (hit(bus_addr, OFF_CTRL))   ctrl_rst_en <= bus_wdata[0];
      if (hit(bus_addr, OFF_ENABLE)) en_run      <= bus_wdata[0];
      if (hit(bus_addr, OFF_MASK))   mask_q      <= bus_wdata[0];
      if (hit(bus_addr, OFF_LOAD))   load_q      <= bus_wdata[CNT_W-1:0];
    end
  end

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(en_run), .reload_stb(reload_stb),
    .load_val(load_q), .cnt(cnt), .expire(expire)
  );

  wdt_irq #(.CLR_HOLD(CLR_HOLD)) u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .rst_en(ctrl_rst_en),
    .clr_req(clr_req), .pending(pending), .busy(busy), .rst_req(rst_req)
  );

  assign irq_o         = pending && !mask_q;
  assign sys_rst_req_o = rst_req;

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      if (hit(bus_addr, OFF_STATUS)) bus_rdata = {31'b0, pending};
      if (hit(bus_addr, OFF_CTRL))   bus_rdata = {31'b0, ctrl_rst_en};
      if (hit(bus_addr, OFF_LOAD))   bus_rdata = 32'(load_q);
      if (hit(bus_addr, OFF_ENABLE)) bus_rdata = {31'b0, en_run};
      if (hit(bus_addr, OFF_VALUE))  bus_rdata = 32'(cnt);
      if (hit(bus_addr, OFF_CLEAR))  bus_rdata = {30'b0, busy, 1'b0};
      if (hit(bus_addr, OFF_MASK))   bus_rdata = {31'b0, mask_q};
      if (hit(bus_addr, OFF_LOCK))   bus_rdata = {31'b0, locked};
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             locked,
  input logic             wr_any,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] cnt,
  input logic             en_run,
  input logic             reload_stb,
  input logic             pending,
  input logic             irq_o,
  input logic             sys_rst_req_o
);
  AST_LOCKED_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_any) |=> $stable(load_q)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_run && !reload_stb && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_run && !reload_stb) |=> $stable(cnt)); // R5
  AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_run && cnt == '0) |=> pending); // R5
  AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> !irq_o); // R6
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |=> !sys_rst_req_o); // R7
  AST_RST_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |-> (pending && $past(pending))); // R7
endmodule

bind keylock_wdt wdt_checker #(.CNT_W(CNT_W)) u_wdt_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .wr_any(wr_any),
  .load_q(load_q), .cnt(cnt), .en_run(en_run), .reload_stb(reload_stb),
  .pending(pending), .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
);

// File: tb/test_keylock_wdt.sv
module test_keylock_wdt;
  localparam logic [31:0] KEY = 32'h378F_0765;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, sys_rst_req_o;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  keylock_wdt i_keylock_wdt (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; commits at next posedge, returns at the following negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic t_reset();
    rd(12'h13C, rv); check("R1 lock", rv, 1);
    rd(12'h108, rv); check("R1 load", rv, 32'hFFFF_FFFF);
    rd(12'h118, rv); check("R1 value", rv, 32'hFFFF_FFFF);
    rd(12'h124, rv); check("R1 mask", rv, 1);
    rd(12'h110, rv); check("R1 enable", rv, 0);
    rd(12'h104, rv); check("R1 ctrl", rv, 0);
    rd(12'h000, rv); check("R1 status", rv, 0);
    check("R1 irq", irq_o, 0);
    check("R1 rst", sys_rst_req_o, 0);
  endtask

  task automatic t_locked_writes();
    wr(12'h108, 5);
    rd(12'h108, rv); check("R3 load ignored", rv, 32'hFFFF_FFFF);
    wr(12'h124, 0);
    rd(12'h124, rv); check("R3 mask ignored", rv, 1);
    wr(12'h114, 0);
    rd(12'h118, rv); check("R3 reload ignored", rv, 32'hFFFF_FFFF);
  endtask

  task automatic t_key();
    wr(12'h13C, KEY);
    rd(12'h13C, rv); check("R2 unlocked", rv, 0);
    wr(12'h13C, 32'h1234_5678);
    rd(12'h13C, rv); check("R2 relocked", rv, 1);
    wr(12'h13C, KEY);
    rd(12'h13C, rv); check("R2 unlocked again", rv, 0);
  endtask

  task automatic t_reload();
    wr(12'h108, 5);
    wr(12'h114, 0);
    rd(12'h118, rv); check("R4 reload data 0", rv, 5);
    wr(12'h108, 9);
    wr(12'h114, 1);
    rd(12'h118, rv); check("R4 reload data 1", rv, 9);
    repeat (3) @(negedge clk);
    rd(12'h118, rv); check("R5 hold disabled", rv, 9);
    wr(12'h108, 5);
    wr(12'h114, 0);
  endtask

  task automatic t_count();
    wr(12'h124, 0);
    wr(12'h104, 1);
    wr(12'h110, 1);           // enable at edge E, now at E+0.5
    repeat (5) @(negedge clk); // E+5.5: count 0
    rd(12'h118, rv); check("R5 reached zero", rv, 0);
    check("R6 irq before expiry", irq_o, 0);
    @(negedge clk);           // E+6.5: expired
    check("R6 irq after expiry", irq_o, 1);
    rd(12'h000, rv); check("R5 status set", rv, 1);
    rd(12'h118, rv); check("R5 reloaded", rv, 5);
    check("R7 no reset on first expiry", sys_rst_req_o, 0);
    repeat (5) @(negedge clk);
    check("R7 reset low before second expiry", sys_rst_req_o, 0);
    @(negedge clk);
    check("R7 reset pulse", sys_rst_req_o, 1);
    @(negedge clk);
    check("R7 reset pulse one cycle", sys_rst_req_o, 0);
    wr(12'h110, 0);
  endtask

  task automatic t_mask_clear();
    wr(12'h124, 1);
    check("R6 masked", irq_o, 0);
    rd(12'h000, rv); check("R6 status kept under mask", rv, 1);
    wr(12'h124, 0);
    check("R6 unmasked", irq_o, 1);
    wr(12'h120, 0);
    rd(12'h000, rv); check("R8 bit0 zero no clear", rv, 1);
    wr(12'h120, 1);
    rd(12'h000, rv); check("R8 cleared", rv, 0);
    check("R8 irq dropped", irq_o, 0);
    rd(12'h120, rv); check("R8 busy cycle 1", rv, 2);
    @(negedge clk);
    rd(12'h120, rv); check("R8 busy cycle 2", rv, 2);
    @(negedge clk);
    rd(12'h120, rv); check("R8 busy over", rv, 0);
  endtask

  task automatic t_unmapped();
    rd(12'h200, rv); check("R9 unmapped", rv, 0);
    rd(12'h114, rv); check("R9 reload reads zero", rv, 0);
    wr(12'h13C, 0);
    wr(12'h110, 1);
    rd(12'h110, rv); check("R3 enable ignored when locked", rv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_locked_writes();
    t_key();
    t_reload();
    t_count();
    t_mask_clear();
    t_unmapped();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule